// File: doc/BRIEF.md
# P/Q Parity Check Engine

This block confirms that stored RAID-6 style parity is still consistent with its data. For every column of a block it receives the data bytes of each source in turn and recomputes two parities. P is the plain XOR of the sources. Q is the GF(2^8) sum of each source multiplied by a per-source coefficient. The block then compares both against the expected parity bytes supplied with the column. A mismatch in any column leaves a flag set for P or for Q. Both flags are published together when the last column has been consumed.

A check starts with a one-cycle `start` pulse that carries the configuration:

- the source count;
- the number of columns;
- which of the two parities is present;
- whether the coefficients are the fixed syndrome powers or a caller-supplied list;
- a mask marking sources that refer to the shared all-zero block.

Requests the engine cannot honour are refused at once with an error. Requests that are accepted open a valid/ready byte stream. That stream closes after the final byte, and a `done` pulse follows.

Top module: `pqchk_top`

## Requirements
- R1: `result` bit 0 is the P-mismatch flag and bit 1 is the Q-mismatch flag. Both read 0 in the cycle after any accepted `start`, and `err` reads 0 after an accepted valid request.
- R2: P for a column is the XOR of all its source bytes. `result[0]` is 1 at `done` when any column's P differed from `exp_p`. The flag is sticky over all columns, and `result` changes only with `done` or with the clear that follows `start`.
- R3: Q for a column is the sum over sources i of c_i times d_i, in GF(2^8) with reduction polynomial 0x11d. `result[1]` is 1 at `done` when any column's Q differed from `exp_q`. In weighted mode (`cfg_syn`=0), c_i is byte i of `cfg_coef` (bits 8i+7..8i), and 0 is a legal coefficient.
- R4: In syndrome mode (`cfg_syn`=1), c_i = {02}^i. `cfg_coef` is then ignored.
- R5: A parity whose enable (`cfg_p_en` or `cfg_q_en`) is 0 is not compared, and its result bit stays 0 whatever bytes arrive on its input.
- R6: A request with fewer than 2 sources is refused.
- R7: A request with more than ENG_SRC-2 sources is refused. ENG_SRC-2 sources are accepted.
- R8: A request with both parity enables at 0, or with a column count of 0, is refused.
- R9: A request whose `cfg_zero_mask` has a 1 for any source index below the source count is refused. Mask bits at or above the source count are ignored.
- R10: Within a column, sources arrive in index order 0 to n-1, one byte per accepted beat (`src_valid` and `src_ready`). `exp_p` and `exp_q` are taken on the beat of the last source. `src_ready` is 1 exactly while a check runs. `done` is a single-cycle pulse in the cycle after the final beat.
- R11: `start` while a check runs is ignored, including any new configuration it carries.
- R12: A refused request gives `done`=1 and `err`=1 in the next cycle. It accepts no data and sets `result` to 0. `err` holds until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request pulse; configuration sampled with it |
| cfg_nsrc | input | CNT_W | Number of data sources |
| cfg_len | input | LEN_W | Number of columns (bytes per source) |
| cfg_p_en | input | 1 | Expected P present |
| cfg_q_en | input | 1 | Expected Q present |
| cfg_syn | input | 1 | 1: syndrome coefficients, 0: coefficients from cfg_coef |
| cfg_coef | input | ENG_SRC*8 | Per-source coefficients, source i in byte i |
| cfg_zero_mask | input | ENG_SRC | Sources marked as the shared all-zero block |
| src_valid | input | 1 | Source byte valid |
| src_ready | output | 1 | Engine accepts a source byte |
| src_data | input | 8 | Source byte |
| exp_p | input | 8 | Expected P byte, taken with the column's last source |
| exp_q | input | 8 | Expected Q byte, taken with the column's last source |
| done | output | 1 | Check finished or request refused (one cycle) |
| err | output | 1 | Last request was refused |
| result | output | 2 | {Q mismatch, P mismatch} |

## Verification
The bench goes after the following corner cases, each with a specific wrong behaviour in mind:

- A fault only in the first column, with later columns clean. A design whose flags are not sticky would report a pass here.
- A zero coefficient, which contributes to P but not to Q.
- Garbage coefficients in syndrome mode. A design that consulted the supplied list would raise a false Q failure.
- Corrupted bytes on a disabled parity. A design that did not gate its comparison would flag it.
- Each rejection limit, checked on both sides: 1 and 2 sources, ENG_SRC-2 and ENG_SRC-1 sources, a zero column count, both parities absent, and zero-mask bits just inside and just outside the active sources. An off-by-one in any limit shows up as a wrongly accepted or wrongly refused request.
- A second `start` in the middle of a run. A design that re-armed on it would drop into a shorter job and pulse `done` early.
- Bubbles in `src_valid`. A design that advanced its source index without a handshake would misalign every coefficient.

// File: rtl/pqchk_pkg.sv
`timescale 1ns/1ps
// pqchk_pkg: shared GF(2^8) helpers for the parity check engine.
// Assumes the field is built on reduction polynomial 0x11d with generator {02}.
package pqchk_pkg;

    localparam logic [7:0] GF_POLY_LOW = 8'h1d;
    localparam int RES_P = 0;
    localparam int RES_Q = 1;

    // Multiply a field element by {02}.
    function automatic logic [7:0] gf_xtime(input logic [7:0] a);
        return {a[6:0], 1'b0} ^ (a[7] ? GF_POLY_LOW : 8'h00);
    endfunction

    // Raise {02} to the power n (constant evaluation for tables).
    function automatic logic [7:0] gf_pow2(input int unsigned n);
        logic [7:0] v;
        v = 8'h01;
        for (int unsigned k = 0; k < n; k++) v = gf_xtime(v);
        return v;
    endfunction

endpackage

// File: rtl/pqchk_gfmul.sv
`timescale 1ns/1ps
// pqchk_gfmul: combinational GF(2^8) multiplier y = a * b.
// Built as a chain of {02} doublings of a, each gated by one bit of b.
// Assumes nothing about the operands; depth is eight XOR stages.
module pqchk_gfmul
    import pqchk_pkg::*;
(
    input  logic [7:0] a,
    input  logic [7:0] b,
    output logic [7:0] y
);
    logic [7:0] dbl [8];
    logic [7:0] acc [9];

    assign dbl[0] = a;
    assign acc[0] = 8'h00;

    generate
        for (genvar k = 0; k < 8; k++) begin : g_stage
            // partial sum: add a*{02}^k when bit k of b is set
            assign acc[k+1] = acc[k] ^ (b[k] ? dbl[k] : 8'h00);
            if (k < 7) begin : g_dbl
                // next doubling of a
                assign dbl[k+1] = gf_xtime(dbl[k]);
            end
        end
    endgenerate

    assign y = acc[8];
endmodule

// File: rtl/pqchk_coef.sv
`timescale 1ns/1ps
// pqchk_coef: selects the coefficient of the current source.
// Syndrome mode yields {02}^idx from a constant table; weighted mode yields
// byte idx of the captured coefficient vector. Assumes idx < ENG_SRC.
module pqchk_coef
    import pqchk_pkg::*;
#(
    parameter int ENG_SRC = 16,
    parameter int IDX_W   = $clog2(ENG_SRC)
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 syn,
    input  logic [ENG_SRC*8-1:0] coef_vec,
    output logic [7:0]           coef
);
    logic [7:0] pow_tab [ENG_SRC];

    generate
        for (genvar i = 0; i < ENG_SRC; i++) begin : g_pow
            // constant syndrome weight of source i
            assign pow_tab[i] = gf_pow2(i);
        end
    endgenerate

    // pick the weight of source idx for the active mode
    always_comb begin
        coef = 8'h00;
        for (int i = 0; i < ENG_SRC; i++) begin
            if (idx == IDX_W'(i)) coef = syn ? pow_tab[i] : coef_vec[i*8 +: 8];
        end
    end
endmodule

// File: rtl/pqchk_admit.sv
`timescale 1ns/1ps
// pqchk_admit: decides whether a request can be run.
// Accepts 2..ENG_SRC-2 sources, at least one parity, a nonzero column count,
// and no active source marked as the shared zero block.
module pqchk_admit #(
    parameter int ENG_SRC = 16,
    parameter int CNT_W   = $clog2(ENG_SRC + 1),
    parameter int LEN_W   = 12
) (
    input  logic [CNT_W-1:0]   nsrc,
    input  logic [LEN_W-1:0]   len,
    input  logic               p_en,
    input  logic               q_en,
    input  logic [ENG_SRC-1:0] zero_mask,
    output logic               ok
);
    localparam int MIN_DATA = 2;
    localparam int MAX_DATA = ENG_SRC - 2;

    logic zero_hit;

    // any zero-block mark on a source that takes part in this check
    always_comb begin
        zero_hit = 1'b0;
        for (int i = 0; i < ENG_SRC; i++) begin
            if (zero_mask[i] && (CNT_W'(i) < nsrc)) zero_hit = 1'b1;
        end
    end

    // all admission conditions together
    always_comb begin
        ok = (nsrc >= CNT_W'(MIN_DATA)) && (nsrc <= CNT_W'(MAX_DATA)) &&
             (p_en || q_en) && (len != '0) && !zero_hit;
    end
endmodule

// File: rtl/pqchk_top.sv
`timescale 1ns/1ps
// pqchk_top: P/Q parity check engine.
// Takes one source byte per handshake, column by column, recomputes P (XOR)
// and Q (GF-weighted sum) and compares them with the expected bytes given on
// the last source of each column. Mismatch flags are sticky and published at
// done. Assumes ENG_SRC >= 4 and that start is held for a single cycle.
module pqchk_top
    import pqchk_pkg::*;
#(
    parameter int ENG_SRC = 16,
    parameter int LEN_W   = 12,
    parameter int CNT_W   = $clog2(ENG_SRC + 1),
    parameter int IDX_W   = $clog2(ENG_SRC)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [CNT_W-1:0]     cfg_nsrc,
    input  logic [LEN_W-1:0]     cfg_len,
    input  logic                 cfg_p_en,
    input  logic                 cfg_q_en,
    input  logic                 cfg_syn,
    input  logic [ENG_SRC*8-1:0] cfg_coef,
    input  logic [ENG_SRC-1:0]   cfg_zero_mask,
    input  logic                 src_valid,
    output logic                 src_ready,
    input  logic [7:0]           src_data,
    input  logic [7:0]           exp_p,
    input  logic [7:0]           exp_q,
    output logic                 done,
    output logic                 err,
    output logic [1:0]           result
);
    // captured request
    logic                 busy;
    logic [CNT_W-1:0]     nsrc_q;
    logic [LEN_W-1:0]     len_q;
    logic                 p_en_q, q_en_q, syn_q;
    logic [ENG_SRC*8-1:0] coef_q;
    // progress and accumulation
    logic [IDX_W-1:0]     idx_q;
    logic [LEN_W-1:0]     col_q;
    logic [7:0]           p_acc, q_acc;
    logic                 p_mis, q_mis;

    logic       admit_ok, start_acc, beat, last_src, last_col;
    logic [7:0] coef_cur, prod, p_next, q_next;
    logic       col_p_bad, col_q_bad;

    pqchk_admit #(.ENG_SRC(ENG_SRC), .CNT_W(CNT_W), .LEN_W(LEN_W)) u_admit (
        .nsrc(cfg_nsrc), .len(cfg_len), .p_en(cfg_p_en), .q_en(cfg_q_en),
        .zero_mask(cfg_zero_mask), .ok(admit_ok)
    );

    pqchk_coef #(.ENG_SRC(ENG_SRC), .IDX_W(IDX_W)) u_coef (
        .idx(idx_q), .syn(syn_q), .coef_vec(coef_q), .coef(coef_cur)
    );

    pqchk_gfmul u_mul (.a(src_data), .b(coef_cur), .y(prod));

    // handshake and position decode
    always_comb begin
        src_ready = busy;
        start_acc = start && !busy;
        beat      = src_valid && busy;
        last_src  = (CNT_W'(idx_q) + CNT_W'(1)) == nsrc_q;
        last_col  = (col_q + LEN_W'(1)) == len_q;
    end

    // column parity including the byte on the bus, and its comparison
    always_comb begin
        p_next    = p_acc ^ src_data;
        q_next    = q_acc ^ prod;
        col_p_bad = p_en_q && (p_next != exp_p);
        col_q_bad = q_en_q && (q_next != exp_q);
    end

    // request capture, refusal and run control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            nsrc_q <= '0;
            len_q  <= '0;
            p_en_q <= 1'b0;
            q_en_q <= 1'b0;
            syn_q  <= 1'b0;
            coef_q <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start_acc) begin
                nsrc_q <= cfg_nsrc;
                len_q  <= cfg_len;
                p_en_q <= cfg_p_en;
                q_en_q <= cfg_q_en;
                syn_q  <= cfg_syn;
                coef_q <= cfg_coef;
                if (admit_ok) begin
                    busy <= 1'b1;
                    err  <= 1'b0;
                end else begin
                    done <= 1'b1;
                    err  <= 1'b1;
                end
            end else if (beat && last_src && last_col) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    // byte accumulation, column stepping and sticky mismatch flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            col_q  <= '0;
            p_acc  <= 8'h00;
            q_acc  <= 8'h00;
            p_mis  <= 1'b0;
            q_mis  <= 1'b0;
            result <= 2'b00;
        end else if (start_acc) begin
            idx_q  <= '0;
            col_q  <= '0;
            p_acc  <= 8'h00;
            q_acc  <= 8'h00;
            p_mis  <= 1'b0;
            q_mis  <= 1'b0;
            result <= 2'b00;
        end else if (beat) begin
            if (last_src) begin
                idx_q <= '0;
                p_acc <= 8'h00;
                q_acc <= 8'h00;
                p_mis <= p_mis | col_p_bad;
                q_mis <= q_mis | col_q_bad;
                if (last_col) begin
                    result[RES_P] <= p_mis | col_p_bad;
                    result[RES_Q] <= q_mis | col_q_bad;
                end else begin
                    col_q <= col_q + LEN_W'(1);
                end
            end else begin
                idx_q <= idx_q + IDX_W'(1);
                p_acc <= p_next;
                q_acc <= q_next;
            end
        end
    end

    // R1
    clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_acc |=> (result == 2'b00));

    // R2
    result_moves_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (result != $past(result)) |-> (done || $past(start_acc)));

    // R5
    absent_p_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !p_en_q) |-> !result[RES_P]);

    // R5
    absent_q_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err && !q_en_q) |-> !result[RES_Q]);

    // R7
    count_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (nsrc_q >= CNT_W'(2) && nsrc_q <= CNT_W'(ENG_SRC - 2)));

    // R10
    finish_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> $past(src_valid && src_ready));

    // R11
    busy_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(nsrc_q) && $stable(len_q)));

    // R12
    refusal_signals_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (done && !src_ready));
endmodule

// File: tb/test_pqchk_top.sv
`timescale 1ns/1ps
module test_pqchk_top;
    localparam int ENG_SRC = 16;
    localparam int LEN_W   = 12;
    localparam int CNT_W   = $clog2(ENG_SRC + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 start = 1'b0;
    logic [CNT_W-1:0]     cfg_nsrc = '0;
    logic [LEN_W-1:0]     cfg_len = '0;
    logic                 cfg_p_en = 1'b0, cfg_q_en = 1'b0, cfg_syn = 1'b0;
    logic [ENG_SRC*8-1:0] cfg_coef = '0;
    logic [ENG_SRC-1:0]   cfg_zero_mask = '0;
    logic                 src_valid = 1'b0;
    logic                 src_ready;
    logic [7:0]           src_data = 8'h00, exp_p = 8'h00, exp_q = 8'h00;
    logic                 done, err;
    logic [1:0]           result;

    int checks = 0;
    int failures = 0;

    // expected port state, kept by the driving tasks
    logic       m_ready = 1'b0, m_done = 1'b0, m_err = 1'b0;
    logic [1:0] m_res = 2'b00;
    bit         mon_en = 1'b0;

    logic [7:0] coef_arr [ENG_SRC];

    always #10 clk = ~clk;

    pqchk_top #(.ENG_SRC(ENG_SRC), .LEN_W(LEN_W)) i_pqchk_top (
        .clk(clk), .rst_n(rst_n), .start(start), .cfg_nsrc(cfg_nsrc),
        .cfg_len(cfg_len), .cfg_p_en(cfg_p_en), .cfg_q_en(cfg_q_en),
        .cfg_syn(cfg_syn), .cfg_coef(cfg_coef), .cfg_zero_mask(cfg_zero_mask),
        .src_valid(src_valid), .src_ready(src_ready), .src_data(src_data),
        .exp_p(exp_p), .exp_q(exp_q), .done(done), .err(err), .result(result)
    );

    task automatic chk(input string req, input int act, input int expv);
        checks++;
        if (act != expv) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [7:0] r, x;
        r = 0; x = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) r = r ^ x;
            x = x[7] ? ((x << 1) ^ 8'h1d) : (x << 1);
        end
        return r;
    endfunction

    function automatic logic [7:0] ref_pow(input int n);
        logic [7:0] v;
        v = 8'h01;
        for (int k = 0; k < n; k++) v = ref_mul(v, 8'h02);
        return v;
    endfunction

    // per-cycle comparison of every output against the model
    always @(negedge clk) begin
        if (mon_en) begin
            chk("R10 src_ready", src_ready, m_ready);
            chk("R10 done", done, m_done);
            chk("R12 err", err, m_err);
            chk("R1 result", result, m_res);
        end
    end

    task automatic load_cfg(input int n, input int len, input bit pen, input bit qen,
                            input bit syn, input logic [ENG_SRC-1:0] zmask);
        cfg_nsrc = CNT_W'(n);
        cfg_len = LEN_W'(len);
        cfg_p_en = pen;
        cfg_q_en = qen;
        cfg_syn = syn;
        cfg_zero_mask = zmask;
        for (int i = 0; i < ENG_SRC; i++) cfg_coef[i*8 +: 8] = coef_arr[i];
    endtask

    // bad: 0 none, 1 corrupt P, 2 corrupt Q, 3 both, applied in column bad_col
    task automatic run_job(input string req, input int n, input int len, input bit pen,
                           input bit qen, input bit syn, input logic [ENG_SRC-1:0] zmask,
                           input int bad_col, input int bad, input int seed, input bit poke);
        logic [7:0] d, pc, qc, c;
        bit fp, fq;
        fp = 0; fq = 0;
        @(posedge clk); #1;
        load_cfg(n, len, pen, qen, syn, zmask);
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        m_ready = 1'b1; m_res = 2'b00; m_err = 1'b0;
        for (int col = 0; col < len; col++) begin
            pc = 0; qc = 0;
            for (int s = 0; s < n; s++) begin
                d = 8'((col * 37 + s * 11 + seed * 53 + s * col) & 255);
                c = syn ? ref_pow(s) : coef_arr[s];
                pc = pc ^ d;
                qc = qc ^ ref_mul(c, d);
                if (((col * 7 + s) % 4) == 3) begin
                    src_valid = 1'b0;
                    @(posedge clk); #1;
                end
                src_valid = 1'b1;
                src_data = d;
                if (s == n - 1) begin
                    exp_p = pc ^ ((col == bad_col && (bad & 1) != 0) ? 8'h40 : 8'h00);
                    exp_q = qc ^ ((col == bad_col && (bad & 2) != 0) ? 8'h05 : 8'h00);
                    if (col == bad_col && (bad & 1) != 0 && pen) fp = 1;
                    if (col == bad_col && (bad & 2) != 0 && qen) fq = 1;
                end else begin
                    exp_p = 8'hA5;
                    exp_q = 8'h3C;
                end
                if (poke && col == 0 && s == 1) begin
                    // R11: a new request while running must be ignored
                    cfg_nsrc = CNT_W'(2);
                    cfg_len = LEN_W'(1);
                    start = 1'b1;
                end
                @(posedge clk); #1;
                start = 1'b0;
            end
        end
        src_valid = 1'b0;
        m_ready = 1'b0; m_done = 1'b1; m_res = {fq, fp};
        @(negedge clk);
        chk(req, result, {fq, fp});
        @(posedge clk); #1;
        m_done = 1'b0;
    endtask

    task automatic run_reject(input string req, input int n, input int len, input bit pen,
                              input bit qen, input logic [ENG_SRC-1:0] zmask);
        @(posedge clk); #1;
        load_cfg(n, len, pen, qen, 1'b1, zmask);
        start = 1'b1;
        src_valid = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        m_done = 1'b1; m_err = 1'b1; m_res = 2'b00;
        @(negedge clk);
        chk(req, {err, src_ready}, 2'b10);
        @(posedge clk); #1;
        m_done = 1'b0;
        src_valid = 1'b0;
    endtask

    initial begin
        #3_000_000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < ENG_SRC; i++) coef_arr[i] = 8'((i * 29 + 3) & 255);
        coef_arr[1] = 8'h00;
        coef_arr[2] = 8'h01;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1 reset result", result, 0);
        chk("R10 reset ready", src_ready, 0);
        chk("R12 reset err", err, 0);
        chk("R10 reset done", done, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;

        // R2/R3/R4 clean syndrome pass
        run_job("R4 syndrome clean", 4, 3, 1, 1, 1, '0, -1, 0, 1, 0);
        // R3 Q fault in a middle column
        run_job("R3 q fault", 4, 3, 1, 1, 1, '0, 1, 2, 2, 0);
        // R2 P fault only in column 0, later columns clean: sticky
        run_job("R2 sticky p fault", 5, 4, 1, 1, 0, '0, 0, 1, 3, 0);
        // R3 weighted coefficients incl. zero and one, clean
        run_job("R3 weighted clean", 6, 2, 1, 1, 0, '0, -1, 0, 4, 0);
        // R3 weighted, both corrupted
        run_job("R3 weighted both", 3, 2, 1, 1, 0, '0, 1, 3, 5, 0);
        // R4: garbage coefficient vector ignored in syndrome mode
        for (int i = 0; i < ENG_SRC; i++) coef_arr[i] = 8'((i * 91 + 17) & 255);
        run_job("R4 coef ignored", 5, 2, 1, 1, 1, '0, -1, 0, 6, 0);
        // R5 absent parities with corrupted inputs
        run_job("R5 p absent", 4, 2, 0, 1, 1, '0, 0, 1, 7, 0);
        run_job("R5 q absent", 4, 2, 1, 0, 1, '0, 1, 2, 8, 0);
        // R6 lower limit
        run_reject("R6 one source", 1, 2, 1, 1, '0);
        run_job("R6 two sources", 2, 2, 1, 1, 1, '0, -1, 0, 9, 0);
        // R7 upper limit
        run_reject("R7 too many", ENG_SRC - 1, 2, 1, 1, '0);
        run_reject("R7 full engine", ENG_SRC, 2, 1, 1, '0);
        run_job("R7 max sources", ENG_SRC - 2, 2, 1, 1, 1, '0, 1, 2, 10, 0);
        // R8 both absent, zero length
        run_reject("R8 no parity", 4, 2, 0, 0, '0);
        run_reject("R8 zero length", 4, 0, 1, 1, '0);
        // R9 zero-block mark inside / outside the active sources
        run_reject("R9 zero block active", 4, 2, 1, 1, 16'h0008);
        run_job("R9 mask above count", 4, 2, 1, 1, 1, 16'hFFF0, -1, 0, 11, 0);
        // R11 start during a run
        run_job("R11 start ignored", 4, 3, 1, 1, 1, '0, 2, 1, 12, 1);
        // R12 error cleared by next accepted request
        run_reject("R12 reject", 0, 2, 1, 1, '0);
        run_job("R12 err cleared", 3, 1, 1, 1, 1, '0, -1, 0, 13, 0);

        repeat (3) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule